// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit in-order integer core. It overlaps up to five instructions across fetch, decode with register read, execute, memory access and write-back. Instruction fetch and data access use two separate memory ports. Both ports read combinationally in the same cycle, so fetch and data access never compete for a port. The core runs a small load/store subset. That subset is seven register-register ALU operations, add-immediate, word load, word store, and two compare-and-branch instructions.

Results reach the execute stage over bypass paths from the two later stages. The core stalls in only two cases. The first is a consumer that needs a word still being loaded. The second is a branch whose operands are not ready yet. Branches are decided in the decode stage, in parallel with the register read, so a taken branch wastes exactly one fetch slot. An asynchronous active-low reset is synchronised inside the block before it is released.

Top module: `pipe_core`

## Requirements
- R1: While reset is held, and after it is released until the first fetch, imem_addr is 0 and dmem_we and dmem_re are 0. Reset clears all 32 general registers to zero.
- R2: With no stall and no redirect, imem_addr advances by 4 each cycle and a new instruction enters the pipeline every cycle. Fetch addresses are always word aligned.
- R3: Opcode 0 selects a register-register operation. The fields are op = bits 31..26, first source = bits 25..21, second source = bits 20..16, destination = bits 15..11 and function = bits 5..0. The function codes are add 32, sub 34, and 36, or 37, xor 38, nor 39 and signed set-less-than 42.
- R4: addi (opcode 8), lw (opcode 35) and sw (opcode 43) sign-extend bits 15..0 and write the register in bits 20..16. lw and sw address memory at base plus offset, and lw writes the loaded word back. A data read and a data write never happen in the same cycle.
- R5: Register 0 always reads as zero, and any write to it is discarded.
- R6: Execute takes a source from the instruction one ahead or two ahead when either one writes that register. When both write it, the nearer (younger) one wins.
- R7: An instruction that reads the register loaded by the lw directly ahead of it, including a store of that register, waits exactly one cycle. During that cycle the fetch address holds and a bubble enters execute. In the test program the first store reaches memory in cycle 21, counting from the cycle that fetches address 0.
- R8: beq (opcode 4) and bne (opcode 5) compare their two sources in decode. When taken, they redirect fetch to PC+4 plus the offset shifted left by 2. The one instruction fetched behind a taken branch is discarded, so it costs one extra cycle.
- R9: A branch stalls in decode while a source is being written by the instruction in execute, or by a load in memory access. An ALU result already in memory access is bypassed to the compare without a stall. With these rules the test program first fetches its final self-loop in cycle 77.
- R10: A register written back in a cycle is seen by the decode-stage read in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the clock edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |

## Verification
A wrong bypass choice, or a missed hazard, leaves a stale operand in the pipeline. That stale operand shows up as a wrong word at a store address, usually within three cycles of the faulty instruction, because the program stores every result register. A missing or extra stall, or a flush that keeps the wrong-path instruction, shifts the cycle of the first store and of the first fetch of the final self-loop by one or more cycles. A flush that keeps the wrong-path instruction also leaves a non-zero value in a register that must stay clear. A register file that survives reset shows up in a second run as a doubled loop accumulator.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SW   = 6'd43;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_BNE  = 6'd5;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_XOR = 6'd38;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT
  } alu_op_e;

  // per-instruction control carried down the pipe
  typedef struct packed {
    logic              wr;   // writes a register
    logic              ld;   // data load
    logic              st;   // data store
    logic              imm;  // second ALU operand is the immediate
    logic              ua;   // reads first source
    logic              ub;   // reads second source
    alu_op_e           op;
    logic [REG_AW-1:0] dst;
  } ctl_t;
endpackage

// File: rtl/pipe_alu.sv
module pipe_alu
  import pipe_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile #(
  parameter int W  = 32,
  parameter int N  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  logic [W-1:0] reg_q [N];
  logic         wr_en;

  assign wr_en = we && (wa != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) reg_q[i] <= '0;
    end else if (wr_en) begin
      reg_q[wa] <= wd;
    end
  end

  // same-cycle write-back is visible to the decode read
  always_comb begin
    qa = (ra == '0) ? '0 : (wr_en && wa == ra) ? wd : reg_q[ra];
    qb = (rb == '0) ? '0 : (wr_en && wa == rb) ? wd : reg_q[rb];
  end
endmodule

// File: rtl/pipe_hazard.sv
module pipe_hazard
  import pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_ua,
  input  logic              id_ub,
  input  logic              id_br,
  input  logic              ex_wr,
  input  logic              ex_ld,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic              ex_ua,
  input  logic              ex_ub,
  input  logic              mem_wr,
  input  logic              mem_ld,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              wb_wr,
  input  logic [REG_AW-1:0] wb_dst,
  output logic              stall,
  output logic [1:0]        ex_fwd_a,
  output logic [1:0]        ex_fwd_b,
  output logic              id_fwd_a,
  output logic              id_fwd_b
);
  function automatic logic hit(input logic wr, input logic [REG_AW-1:0] dst,
                               input logic [REG_AW-1:0] src);
    return wr && (dst != '0) && (dst == src);
  endfunction

  logic load_use, br_wait;

  always_comb begin
    load_use = ex_ld && ((id_ua && hit(ex_wr, ex_dst, id_rs)) ||
                         (id_ub && hit(ex_wr, ex_dst, id_rt)));
    br_wait  = id_br && (hit(ex_wr, ex_dst, id_rs) || hit(ex_wr, ex_dst, id_rt) ||
                         (mem_ld && (hit(mem_wr, mem_dst, id_rs) ||
                                     hit(mem_wr, mem_dst, id_rt))));
    stall    = load_use || br_wait;
    // 1 = from the stage ahead (younger), 2 = from write-back
    ex_fwd_a = hit(mem_wr, mem_dst, ex_rs) ? 2'd1 : hit(wb_wr, wb_dst, ex_rs) ? 2'd2 : 2'd0;
    ex_fwd_b = hit(mem_wr, mem_dst, ex_rt) ? 2'd1 : hit(wb_wr, wb_dst, ex_rt) ? 2'd2 : 2'd0;
    id_fwd_a = !mem_ld && hit(mem_wr, mem_dst, id_rs);
    id_fwd_b = !mem_ld && hit(mem_wr, mem_dst, id_rt);
  end

  AST_NO_LOAD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n) !(mem_ld && ((ex_ua && ex_fwd_a == 2'd1) || (ex_ub && ex_fwd_b == 2'd1)))); // R7
endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import pipe_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              NREG        = 32,
  parameter int              SYNC_STAGES = 2,
  parameter logic [XLEN-1:0] RESET_PC    = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // reset: asserted at once, released on the clock
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rsync_q[SYNC_STAGES-1];

  // pipeline state
  logic [XLEN-1:0] pc_q, pc_d;
  logic            ifid_v_q, ifid_v_d;
  logic [31:0]     ifid_ir_q, ifid_ir_d;
  logic [XLEN-1:0] ifid_pc4_q, ifid_pc4_d;
  ctl_t            idex_ctl_q, idex_ctl_d;
  logic [XLEN-1:0] idex_a_q, idex_b_q, idex_imm_q;
  logic [REG_AW-1:0] idex_rs_q, idex_rt_q;
  ctl_t            exmem_ctl_q;
  logic [XLEN-1:0] exmem_y_q, exmem_sd_q;
  logic            memwb_wr_q;
  logic [REG_AW-1:0] memwb_dst_q;
  logic [XLEN-1:0] memwb_val_q, memwb_val_d;

  // decode
  logic [5:0]        id_op, id_fn;
  logic [REG_AW-1:0] id_rs, id_rt, id_rd;
  logic [XLEN-1:0]   id_imm, rf_qa, rf_qb, br_a, br_b, br_tgt;
  ctl_t              id_ctl;
  logic              id_br, id_bne, taken, stall, id_fwd_a, id_fwd_b;
  logic [1:0]        ex_fwd_a, ex_fwd_b;

  always_comb begin
    id_op  = ifid_ir_q[31:26];
    id_rs  = ifid_ir_q[25:21];
    id_rt  = ifid_ir_q[20:16];
    id_rd  = ifid_ir_q[15:11];
    id_fn  = ifid_ir_q[5:0];
    id_imm = {{(XLEN-16){ifid_ir_q[15]}}, ifid_ir_q[15:0]};
    id_ctl = '0;
    id_br  = 1'b0;
    id_bne = 1'b0;
    if (ifid_v_q) begin
      case (id_op)
        OP_REG: begin
          id_ctl.ua = 1'b1; id_ctl.ub = 1'b1; id_ctl.dst = id_rd; id_ctl.wr = 1'b1;
          case (id_fn)
            FN_ADD:  id_ctl.op = ALU_ADD;
            FN_SUB:  id_ctl.op = ALU_SUB;
            FN_AND:  id_ctl.op = ALU_AND;
            FN_OR:   id_ctl.op = ALU_OR;
            FN_XOR:  id_ctl.op = ALU_XOR;
            FN_NOR:  id_ctl.op = ALU_NOR;
            FN_SLT:  id_ctl.op = ALU_SLT;
            default: id_ctl.wr = 1'b0;
          endcase
        end
        OP_ADDI: begin id_ctl.wr = 1'b1; id_ctl.ua = 1'b1; id_ctl.imm = 1'b1; id_ctl.dst = id_rt; end
        OP_LW: begin
          id_ctl.wr = 1'b1; id_ctl.ld = 1'b1; id_ctl.ua = 1'b1; id_ctl.imm = 1'b1; id_ctl.dst = id_rt;
        end
        OP_SW:  begin id_ctl.st = 1'b1; id_ctl.ua = 1'b1; id_ctl.ub = 1'b1; id_ctl.imm = 1'b1; end
        OP_BEQ: begin id_br = 1'b1; id_ctl.ua = 1'b1; id_ctl.ub = 1'b1; end
        OP_BNE: begin id_br = 1'b1; id_bne = 1'b1; id_ctl.ua = 1'b1; id_ctl.ub = 1'b1; end
        default: ;
      endcase
    end
    br_a   = id_fwd_a ? exmem_y_q : rf_qa;
    br_b   = id_fwd_b ? exmem_y_q : rf_qb;
    br_tgt = ifid_pc4_q + (id_imm << 2);
    taken  = id_br && !stall && ((br_a == br_b) != id_bne);
  end

  pipe_regfile #(.W(XLEN), .N(NREG), .AW(REG_AW)) u_rf (
    .clk(clk), .rst_n(rst_i), .we(memwb_wr_q), .wa(memwb_dst_q), .wd(memwb_val_q),
    .ra(id_rs), .rb(id_rt), .qa(rf_qa), .qb(rf_qb)
  );

  pipe_hazard u_hz (
    .clk(clk), .rst_n(rst_i),
    .id_rs(id_rs), .id_rt(id_rt), .id_ua(id_ctl.ua), .id_ub(id_ctl.ub), .id_br(id_br),
    .ex_wr(idex_ctl_q.wr), .ex_ld(idex_ctl_q.ld), .ex_dst(idex_ctl_q.dst),
    .ex_rs(idex_rs_q), .ex_rt(idex_rt_q), .ex_ua(idex_ctl_q.ua), .ex_ub(idex_ctl_q.ub),
    .mem_wr(exmem_ctl_q.wr), .mem_ld(exmem_ctl_q.ld), .mem_dst(exmem_ctl_q.dst),
    .wb_wr(memwb_wr_q), .wb_dst(memwb_dst_q),
    .stall(stall), .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
    .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b)
  );

  // execute
  logic [XLEN-1:0] ex_a, ex_b, ex_y;
  always_comb begin
    case (ex_fwd_a)
      2'd1:    ex_a = exmem_y_q;
      2'd2:    ex_a = memwb_val_q;
      default: ex_a = idex_a_q;
    endcase
    case (ex_fwd_b)
      2'd1:    ex_b = exmem_y_q;
      2'd2:    ex_b = memwb_val_q;
      default: ex_b = idex_b_q;
    endcase
  end

  pipe_alu #(.W(XLEN)) u_alu (
    .op(idex_ctl_q.op), .a(ex_a), .b(idex_ctl_q.imm ? idex_imm_q : ex_b), .y(ex_y)
  );

  // memory access
  assign imem_addr  = pc_q;
  assign dmem_addr  = exmem_y_q;
  assign dmem_wdata = exmem_sd_q;
  assign dmem_we    = exmem_ctl_q.st;
  assign dmem_re    = exmem_ctl_q.ld;

  // next state
  always_comb begin
    pc_d        = taken ? br_tgt : pc_q + STEP;
    ifid_v_d    = !taken;
    ifid_ir_d   = imem_rdata;
    ifid_pc4_d  = pc_q + STEP;
    idex_ctl_d  = stall ? '0 : id_ctl;
    memwb_val_d = exmem_ctl_q.ld ? dmem_rdata : exmem_y_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pc_q        <= RESET_PC;
      ifid_v_q    <= 1'b0;
      ifid_ir_q   <= '0;
      ifid_pc4_q  <= '0;
      idex_ctl_q  <= '0;
      idex_a_q    <= '0;
      idex_b_q    <= '0;
      idex_imm_q  <= '0;
      idex_rs_q   <= '0;
      idex_rt_q   <= '0;
      exmem_ctl_q <= '0;
      exmem_y_q   <= '0;
      exmem_sd_q  <= '0;
      memwb_wr_q  <= 1'b0;
      memwb_dst_q <= '0;
      memwb_val_q <= '0;
    end else begin
      if (!stall) begin
        pc_q       <= pc_d;
        ifid_v_q   <= ifid_v_d;
        ifid_ir_q  <= ifid_ir_d;
        ifid_pc4_q <= ifid_pc4_d;
      end
      idex_ctl_q  <= idex_ctl_d;
      idex_a_q    <= rf_qa;
      idex_b_q    <= rf_qb;
      idex_imm_q  <= id_imm;
      idex_rs_q   <= id_rs;
      idex_rt_q   <= id_rt;
      exmem_ctl_q <= idex_ctl_q;
      exmem_y_q   <= ex_y;
      exmem_sd_q  <= ex_b;
      memwb_wr_q  <= exmem_ctl_q.wr;
      memwb_dst_q <= exmem_ctl_q.dst;
      memwb_val_q <= memwb_val_d;
    end
  end

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_i) imem_addr[1:0] == 2'b00); // R2
  AST_STALL_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rst_i) stall |=> $stable(imem_addr)); // R7
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_i) stall |=> (!idex_ctl_q.wr && !idex_ctl_q.ld && !idex_ctl_q.st)); // R7
  AST_TAKEN_FLUSH: assert property (@(posedge clk) disable iff (!rst_i) taken |=> !ifid_v_q); // R8
  AST_DMEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_i) !(dmem_we && dmem_re)); // R4
endmodule

// File: tb/tb_pipe_core.sv
`timescale 1ns/1ps
module tb_pipe_core;
  function automatic logic [31:0] enc_r(input int fn, input int rd, input int rs, input int rt);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(input int op, input int rt, input int rs, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  localparam logic [31:0] HALT = 32'h1000_ffff;  // beq r0,r0,-1
  localparam int NPROG = 62;
  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(8, 1, 0, 5), enc_i(8, 2, 0, -3),
    enc_r(32, 3, 1, 2), enc_r(34, 4, 3, 1), enc_r(36, 5, 1, 2), enc_r(37, 6, 1, 2),
    enc_r(38, 7, 1, 2), enc_r(39, 8, 1, 2), enc_r(42, 9, 2, 1), enc_r(42, 10, 1, 2),
    enc_i(8, 11, 0, 1), enc_i(8, 11, 0, 2), enc_r(32, 12, 11, 0),
    enc_i(35, 13, 0, 0), enc_r(32, 14, 13, 13),
    enc_i(35, 15, 0, 4), enc_i(43, 15, 0, 400),
    enc_i(8, 0, 0, 9), enc_r(32, 16, 0, 1),
    enc_i(8, 17, 0, 11), 32'h0, 32'h0, enc_r(32, 18, 17, 17),
    enc_i(8, 19, 0, 3), enc_i(4, 19, 19, 1), enc_i(8, 20, 0, 99),
    enc_i(8, 22, 0, 6), 32'h0, enc_i(5, 0, 22, 1), enc_i(8, 20, 0, 77),
    enc_i(35, 23, 0, 8), enc_i(4, 0, 23, 1), enc_i(8, 24, 0, 55),
    enc_i(8, 25, 0, 3), enc_i(8, 26, 26, 2), enc_i(8, 25, 25, -1), enc_i(5, 0, 25, -3),
    enc_i(43, 3, 0, 256), enc_i(43, 4, 0, 260), enc_i(43, 5, 0, 264), enc_i(43, 6, 0, 268),
    enc_i(43, 7, 0, 272), enc_i(43, 8, 0, 276), enc_i(43, 9, 0, 280), enc_i(43, 10, 0, 284),
    enc_i(43, 11, 0, 288), enc_i(43, 12, 0, 292), enc_i(43, 13, 0, 296), enc_i(43, 14, 0, 300),
    enc_i(43, 15, 0, 304), enc_i(43, 16, 0, 308), enc_i(43, 17, 0, 312), enc_i(43, 18, 0, 316),
    enc_i(43, 19, 0, 320), enc_i(43, 20, 0, 324), enc_i(43, 21, 0, 328), enc_i(43, 22, 0, 332),
    enc_i(43, 23, 0, 336), enc_i(43, 24, 0, 340), enc_i(43, 25, 0, 344), enc_i(43, 26, 0, 348),
    HALT
  };

  // result words to compare and the requirement each one exercises
  localparam int NCHK = 25;
  localparam int CHK_WORD [NCHK] = '{64, 65, 66, 67, 68, 69, 70, 71, 72, 73, 74, 75, 76, 77,
                                     78, 79, 80, 81, 82, 83, 84, 85, 86, 87, 100};
  localparam int CHK_REQ  [NCHK] = '{3, 3, 3, 3, 3, 3, 3, 3, 6, 6, 4, 7, 7, 5,
                                     4, 10, 9, 8, 8, 9, 4, 9, 8, 8, 7};

  function automatic string req_name(input int k);
    case (k)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";  5: return "R5";
      6: return "R6";  7: return "R7";  8: return "R8";  9: return "R9";  default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] init_word(input int i);
    return (i < 8) ? 32'h1000_0000 + 32'(i) * 32'h111 + 32'h7 : 32'h0;
  endfunction

  logic        clk, rst_n, restore;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;
  logic [31:0] dm [128];
  logic [31:0] ref_mem [128];
  int          checks, errors;
  bit          done;

  pipe_core dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_rdata(dmem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign imem_rdata = (int'(imem_addr[31:2]) < NPROG) ? PROG[imem_addr[7:2]] : 32'h0;
  assign dmem_rdata = dm[dmem_addr[8:2]];

  always @(posedge clk) begin
    if (restore) begin
      for (int i = 0; i < 128; i++) dm[i] <= init_word(i);
    end else if (dmem_we) begin
      dm[dmem_addr[8:2]] <= dmem_wdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // instruction-level reference model
  task automatic run_ref();
    logic [31:0] r [32];
    logic [31:0] pc, ir, a, b, imm, ea;
    for (int i = 0; i < 32; i++) r[i] = 32'h0;
    for (int i = 0; i < 128; i++) ref_mem[i] = init_word(i);
    pc = 32'h0;
    for (int step = 0; step < 2000; step++) begin
      ir = (int'(pc[31:2]) < NPROG) ? PROG[pc[7:2]] : 32'h0;
      if (ir == HALT) break;
      a   = r[ir[25:21]];
      b   = r[ir[20:16]];
      imm = {{16{ir[15]}}, ir[15:0]};
      ea  = a + imm;
      pc  = pc + 4;
      case (ir[31:26])
        6'd0: case (ir[5:0])
          6'd32: r[ir[15:11]] = a + b;
          6'd34: r[ir[15:11]] = a - b;
          6'd36: r[ir[15:11]] = a & b;
          6'd37: r[ir[15:11]] = a | b;
          6'd38: r[ir[15:11]] = a ^ b;
          6'd39: r[ir[15:11]] = ~(a | b);
          6'd42: r[ir[15:11]] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: ;
        endcase
        6'd8:  r[ir[20:16]] = ea;
        6'd35: r[ir[20:16]] = ref_mem[ea[8:2]];
        6'd43: ref_mem[ea[8:2]] = b;
        6'd4:  if (a == b) pc = pc + (imm << 2);
        6'd5:  if (a != b) pc = pc + (imm << 2);
        default: ;
      endcase
      r[0] = 32'h0;
    end
  endtask

  task automatic compare_results(input string pass_name);
    for (int k = 0; k < NCHK; k++) begin
      chk(req_name(CHK_REQ[k]), $sformatf("%s word %0d", pass_name, CHK_WORD[k]),
          dm[CHK_WORD[k]], ref_mem[CHK_WORD[k]]);
    end
  endtask

  // timing run: cycle 0 is the last cycle that fetches address 0
  task automatic timed_run(input string pass_name);
    int n, cyc, first_we, first_halt;
    n = 0;
    while (imem_addr !== 32'd4 && n < 50) begin
      @(negedge clk);
      n++;
    end
    cyc = 1; first_we = -1; first_halt = -1;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) chk("R2", "fetch step", imem_addr, 32'd8);
      if (cyc == 3) chk("R2", "fetch step", imem_addr, 32'd12);
      if (dmem_we && first_we < 0) first_we = cyc;
      if (imem_addr == 32'd244 && first_halt < 0) first_halt = cyc;
    end
    chk("R7", {pass_name, " first store cycle"}, 32'(first_we), 32'd21);
    chk("R9", {pass_name, " self-loop fetch cycle (R8 flush cost)"}, 32'(first_halt), 32'd77);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; restore = 1'b1;
    run_ref();
    repeat (3) @(negedge clk);
    chk("R1", "fetch address in reset", imem_addr, 32'h0);
    chk("R1", "store strobe in reset", {31'h0, dmem_we}, 32'h0);
    chk("R1", "load strobe in reset", {31'h0, dmem_re}, 32'h0);
    restore = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "fetch address held by reset sync", imem_addr, 32'h0);
    timed_run("pass1");
    compare_results("pass1");
    // R1: reset mid-run must clear the register file (loop accumulator r26 restarts)
    rst_n = 1'b0;
    restore = 1'b1;
    #1;
    chk("R1", "fetch address after async reset", imem_addr, 32'h0);
    chk("R1", "store strobe after async reset", {31'h0, dmem_we}, 32'h0);
    repeat (2) @(negedge clk);
    restore = 1'b0;
    rst_n = 1'b1;
    timed_run("pass2");
    compare_results("pass2");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule